// File: doc/BRIEF.md
# I2C Serial Clock Generator with Prescaler

This block produces the serial clock for an I2C bus engine from the module's input clock. A programmable prescaler first divides the input clock by `psc + 1`, giving an internal time base. Two phase counters then count that time base: one for the part of the period where the clock line is driven low, and one for the part where it is released high. Each phase lasts its programmed count plus a fixed extension `d`. The extension depends on the prescale value: 7 for a prescale of zero, 6 for a prescale of one, and 5 for any larger prescale. One full period is therefore `(psc+1)*((low+d)+(high+d))` input clocks. The prescale value is meant to bring the internal time base into the 7 to 12 MHz range.

The generator only drives the line low or releases it. Before the high phase is counted, it waits until the synchronized bus line actually reads high. A slave can therefore stretch the clock by holding the line low. At the first cycle of each low phase and of each high phase, a one-cycle strobe is raised so that a bus engine can shift data at those points. The three configuration words are latched only at phase boundaries, so new values written during operation apply from the next phase. While the enable is low, the line is released and every counter sits at zero.

Top module: `scl_clkgen`

## Requirements
- R1: While and right after synchronous reset, `scl_o` is 1 (line released) and both `low_start` and `high_start` are 0.
- R2: When `en` is sampled low at a clock edge, the next cycle shows `scl_o` = 1 and no strobes, whatever phase was running, and this holds for as long as `en` stays low.
- R3: The phase extension `d` is 7 when the active prescale is 0, 6 when it is 1, and 5 when it is 2 or more.
- R4: A low phase keeps `scl_o` = 0 for exactly `(psc+1)*(low_cfg+d)` consecutive input clock cycles, starting with the cycle in which `low_start` is 1.
- R5: From the cycle in which `high_start` is 1 up to the cycle before the next `low_start`, exactly `(psc+1)*(high_cfg+d)` cycles pass, with `scl_o` = 1 throughout.
- R6: After a low phase ends, `scl_o` is 1 but `high_start` is not raised and high counting does not begin until the synchronized `scl_in` reads 1. A line held low keeps the block waiting for as long as it is held.
- R7: `low_start` and `high_start` are each one cycle wide, are never 1 together, and `low_start` falls in the first cycle with `scl_o` = 0.
- R8: The values of `psc_cfg`, `low_cfg` and `high_cfg` are sampled only when a phase begins. A change made during a low phase leaves that low phase unchanged. A new `high_cfg` applies to the high phase that follows, and a new `low_cfg` applies to the next low phase.
- R9: When `en` is first sampled high after being low, `low_start` is 1 in the following cycle and a low phase begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low releases the line and clears counters |
| psc_cfg | input | 16 | Prescale value; the time base is clk divided by psc_cfg+1 |
| low_cfg | input | 16 | Low-phase count, before the extension is added |
| high_cfg | input | 16 | High-phase count, before the extension is added |
| scl_in | input | 1 | Sampled bus clock line (asynchronous) |
| scl_o | output | 1 | 0 = drive line low, 1 = release line |
| low_start | output | 1 | One-cycle strobe in the first cycle of each low phase |
| high_start | output | 1 | One-cycle strobe in the first cycle of each high phase |

## Verification
The bench builds the block with its default parameters: 16-bit configuration words and a two-stage line synchronizer. It programs small phase counts, which keep each period within a few dozen cycles, so every branch of the extension rule can be measured. The prescale values used are 0, 1, 2, 3 and 4, covering each of the three extension values and the divider's wrap both at one and at several stages. The two-stage synchronizer makes the stretch release latency short and fixed. This allows a tight bound to be checked after the bench model stops holding the line low.

// File: rtl/scl_pkg.sv
`timescale 1ns/1ps
package scl_pkg;

    localparam int CFG_W = 16;          // width of each configuration word
    localparam int EXT_W = 3;           // width of the phase extension
    localparam int LEN_W = CFG_W + 1;   // phase length incl. extension

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

    typedef struct packed {
        logic [CFG_W-1:0] psc;
        logic [CFG_W-1:0] low;
        logic [CFG_W-1:0] high;
    } clk_cfg_t;

    // fixed per-phase extension chosen by the prescale value
    function automatic logic [EXT_W-1:0] phase_ext(input logic [CFG_W-1:0] psc);
        if (psc == '0)
            return EXT_W'(7);
        else if (psc == CFG_W'(1))
            return EXT_W'(6);
        else
            return EXT_W'(5);
    endfunction

    function automatic logic [LEN_W-1:0] phase_len(input logic [CFG_W-1:0] cnt,
                                                   input logic [CFG_W-1:0] psc);
        return {1'b0, cnt} + LEN_W'(phase_ext(psc));
    endfunction

endpackage

// File: rtl/scl_line_sync.sv
`timescale 1ns/1ps
module scl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sr <= '1;
                else     sr <= line_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr <= '1;
                else     sr <= {sr[STAGES-2:0], line_in};
            end
        end
    endgenerate

    assign line_q = sr[STAGES-1];
endmodule

// File: rtl/scl_prescale.sv
`timescale 1ns/1ps
module scl_prescale
    import scl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CFG_W-1:0] div,
    output logic             tick
);
    logic [CFG_W-1:0] pcnt;

    assign tick = run && (pcnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run)
            pcnt <= '0;
        else if (tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + CFG_W'(1);
    end

    AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (rst)
        run |-> (pcnt <= div)) else $error("prescale count past divisor"); // R4

    AST_PRESCALE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !$past(run) |-> (pcnt == '0)) else $error("prescale not cleared"); // R2

endmodule

// File: rtl/scl_phase_fsm.sv
`timescale 1ns/1ps
module scl_phase_fsm
    import scl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  clk_cfg_t cfg_in,
    input  logic     line_high,
    input  logic     tick,
    output clk_cfg_t cfg_act,
    output phase_e   phase,
    output logic     low_start,
    output logic     high_start
);
    logic [LEN_W-1:0] ccnt;
    logic [LEN_W-1:0] low_len;
    logic [LEN_W-1:0] high_len;
    logic [LEN_W-1:0] last_cnt;
    logic             phase_done;

    assign low_len    = phase_len(cfg_act.low,  cfg_act.psc);
    assign high_len   = phase_len(cfg_act.high, cfg_act.psc);
    assign last_cnt   = (phase == PH_LOW) ? (low_len - LEN_W'(1)) : (high_len - LEN_W'(1));
    assign phase_done = tick && (ccnt == last_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            ccnt       <= '0;
            cfg_act    <= '0;
            low_start  <= 1'b0;
            high_start <= 1'b0;
        end else if (!en) begin
            phase      <= PH_IDLE;
            ccnt       <= '0;
            cfg_act    <= cfg_in;
            low_start  <= 1'b0;
            high_start <= 1'b0;
        end else begin
            low_start  <= 1'b0;
            high_start <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    phase     <= PH_LOW;
                    cfg_act   <= cfg_in;
                    ccnt      <= '0;
                    low_start <= 1'b1;
                end
                PH_LOW: begin
                    if (phase_done) begin
                        phase <= PH_WAIT;
                        ccnt  <= '0;
                    end else if (tick) begin
                        ccnt <= ccnt + LEN_W'(1);
                    end
                end
                PH_WAIT: begin
                    if (line_high) begin
                        phase      <= PH_HIGH;
                        cfg_act    <= cfg_in;
                        ccnt       <= '0;
                        high_start <= 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (phase_done) begin
                        phase     <= PH_LOW;
                        cfg_act   <= cfg_in;
                        ccnt      <= '0;
                        low_start <= 1'b1;
                    end else if (tick) begin
                        ccnt <= ccnt + LEN_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(low_start && high_start)) else $error("both strobes high"); // R7

    AST_LOW_PULSE: assert property (@(posedge clk) disable iff (rst)
        low_start |=> !low_start) else $error("low strobe too wide"); // R7

    AST_HIGH_PULSE: assert property (@(posedge clk) disable iff (rst)
        high_start |=> !high_start) else $error("high strobe too wide"); // R7

    AST_HIGH_AFTER_LINE: assert property (@(posedge clk) disable iff (rst)
        high_start |-> $past(line_high)) else $error("high began on low line"); // R6

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> (phase == PH_IDLE && !low_start && !high_start)) else $error("active while disabled"); // R2

    AST_LOW_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOW) |-> (ccnt < low_len)) else $error("low count overrun"); // R4

    AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HIGH) |-> (ccnt < high_len)) else $error("high count overrun"); // R5

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOW && $past(phase) == PH_LOW) |-> $stable(cfg_act)) else $error("config moved mid-phase"); // R8

endmodule

// File: rtl/scl_clkgen.sv
`timescale 1ns/1ps
module scl_clkgen
    import scl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CFG_W-1:0] psc_cfg,
    input  logic [CFG_W-1:0] low_cfg,
    input  logic [CFG_W-1:0] high_cfg,
    input  logic             scl_in,
    output logic             scl_o,
    output logic             low_start,
    output logic             high_start
);
    clk_cfg_t cfg_in;
    clk_cfg_t cfg_act;
    phase_e   phase;
    logic     line_high;
    logic     tick;
    logic     run;

    assign cfg_in = '{psc: psc_cfg, low: low_cfg, high: high_cfg};
    assign run    = en && (phase == PH_LOW || phase == PH_HIGH);
    assign scl_o  = (phase != PH_LOW);

    scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .line_in (scl_in),
        .line_q  (line_high)
    );

    scl_prescale u_psc (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .div  (cfg_act.psc),
        .tick (tick)
    );

    scl_phase_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .cfg_in     (cfg_in),
        .line_high  (line_high),
        .tick       (tick),
        .cfg_act    (cfg_act),
        .phase      (phase),
        .low_start  (low_start),
        .high_start (high_start)
    );

    AST_LOW_STROBE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        low_start |-> !scl_o) else $error("low strobe while released"); // R7

    AST_HIGH_STROBE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        high_start |-> scl_o) else $error("high strobe while driven"); // R5

    AST_RESET_RELEASE: assert property (@(posedge clk)
        $past(rst) |-> (scl_o && !low_start && !high_start)) else $error("not released after reset"); // R1

endmodule

// File: tb/scl_clkgen_test.sv
`timescale 1ns/1ps
module scl_clkgen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [15:0] psc_cfg = '0;
    logic [15:0] low_cfg = '0;
    logic [15:0] high_cfg = '0;
    logic        stretch = 1'b0;
    logic        scl_in;
    logic        scl_o;
    logic        low_start;
    logic        high_start;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 1'b0;

    // open-drain bus model: the line is high only when nobody pulls it low
    assign scl_in = scl_o & ~stretch;

    always #2.5 clk = ~clk;

    scl_clkgen uut (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .psc_cfg    (psc_cfg),
        .low_cfg    (low_cfg),
        .high_cfg   (high_cfg),
        .scl_in     (scl_in),
        .scl_o      (scl_o),
        .low_start  (low_start),
        .high_start (high_start)
    );

    // vector table: prescale, low count, high count, expected low and high lengths
    localparam int NV = 5;
    localparam int V_PSC  [NV] = '{0, 1, 2, 4, 3};
    localparam int V_LOW  [NV] = '{3, 4, 0, 2, 10};
    localparam int V_HIGH [NV] = '{2, 1, 3, 0, 5};
    localparam int V_ELOW [NV] = '{10, 20, 15, 35, 60};
    localparam int V_EHIGH[NV] = '{9, 14, 24, 25, 40};

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic measure_low(output int n);
        n = 0;
        while (scl_o == 1'b0 && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_high_start();
        int g = 0;
        while (!high_start && g < 1000) begin
            g++;
            @(negedge clk);
        end
    endtask

    task automatic measure_high(output int n);
        n = 0;
        do begin
            n++;
            @(negedge clk);
        end while (!low_start && n < 100000);
    endtask

    task automatic start_cfg(input int p, input int l, input int h);
        en = 1'b0;
        repeat (2) @(negedge clk);
        psc_cfg  = 16'(p);
        low_cfg  = 16'(l);
        high_cfg = 16'(h);
        en = 1'b1;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog R4 actual=%0d expected=%0d", cycles, 150000);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int n;
        int g;
        bit seen;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(scl_o == 1'b1, "R1 scl during reset", int'(scl_o), 1);
        chk(low_start == 1'b0 && high_start == 1'b0, "R1 strobes during reset", int'(low_start | high_start), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(scl_o == 1'b1, "R1 scl after reset", int'(scl_o), 1);

        // table walk: R3 extension rule, R4 low length, R5 high length, R9 start
        for (int i = 0; i < NV; i++) begin
            start_cfg(V_PSC[i], V_LOW[i], V_HIGH[i]);
            chk(low_start == 1'b1, "R9 low_start one cycle after enable", int'(low_start), 1);
            measure_low(n);
            chk(n == V_ELOW[i], "R4 low length (R3 extension)", n, V_ELOW[i]);
            wait_high_start();
            measure_high(n);
            chk(n == V_EHIGH[i], "R5 high length (R3 extension)", n, V_EHIGH[i]);
        end

        // R7: strobe width, exclusivity and alignment with the falling line
        start_cfg(0, 1, 1);
        chk(low_start == 1'b1 && scl_o == 1'b0, "R7 low_start in first low cycle", int'(scl_o), 0);
        @(negedge clk);
        chk(low_start == 1'b0, "R7 low_start one cycle wide", int'(low_start), 0);
        wait_high_start();
        chk(high_start == 1'b1 && low_start == 1'b0, "R7 strobes exclusive", int'(low_start), 0);
        @(negedge clk);
        chk(high_start == 1'b0, "R7 high_start one cycle wide", int'(high_start), 0);

        // R6: slave holds the line low after the low phase
        start_cfg(0, 2, 2);
        stretch = 1'b1;
        measure_low(n);
        chk(n == 9, "R6 low length under stretch", n, 9);
        seen = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (high_start || !scl_o) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R6 no high phase while line held", int'(seen), 0);
        stretch = 1'b0;
        g = 0;
        while (!high_start && g < 10) begin
            g++;
            @(negedge clk);
        end
        chk(g <= 4 && high_start, "R6 high begins after line release", g, 3);
        measure_high(n);
        chk(n == 9, "R6 high length after stretch", n, 9);

        // R8: configuration changed during a low phase
        start_cfg(0, 3, 2);
        low_cfg  = 16'd9;
        high_cfg = 16'd5;
        measure_low(n);
        chk(n == 10, "R8 current low unchanged", n, 10);
        wait_high_start();
        measure_high(n);
        chk(n == 12, "R8 new high applied at boundary", n, 12);
        measure_low(n);
        chk(n == 16, "R8 new low applied at next low", n, 16);

        // R2: enable dropped in the middle of a low phase
        start_cfg(1, 6, 6);
        repeat (5) @(negedge clk);
        chk(scl_o == 1'b0, "R2 precondition line low", int'(scl_o), 0);
        en = 1'b0;
        @(negedge clk);
        chk(scl_o == 1'b1 && !low_start && !high_start, "R2 released next cycle", int'(scl_o), 1);
        seen = 1'b0;
        for (int k = 0; k < 10; k++) begin
            if (!scl_o || low_start || high_start) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R2 stays released while disabled", int'(seen), 0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule